// File: doc/BRIEF.md
# Four-State Game Flow Controller

This block sequences a simple game through four phases: a start screen, active play, a group vote and a final end screen. It is a Moore machine held in two state flops. One button input steers the branches. Three status lines come straight from the state: one asks for the game theme, one asks the player to do tasks, and one asks for tense music. The next-state bits and the status lines are each a minimized sum of products over the two state bits and the button.

After a synchronous reset the machine sits on the start screen. On the next edge it always moves into play. Play lasts until the button calls a vote. The vote either sends the game back to the start screen or ends it. The end screen holds until reset.

Top module: `gctl_game_fsm`

## Requirements
- R1: Reset is synchronous and active high. While `rst_i` is high at a rising edge, the state becomes Start (code 00). Raising `rst_i` between edges leaves the outputs unchanged until the next edge.
- R2: From Start (00) the next edge always moves to Play (01), for either value of `btn_i`.
- R3: In Play (01), an edge with `btn_i` = 0 stays in Play. An edge with `btn_i` = 1 moves to Vote (10).
- R4: In Vote (10), an edge with `btn_i` = 1 moves to Over (11). An edge with `btn_i` = 0 returns to Start (00).
- R5: Over (11) holds across any number of edges, whatever `btn_i` is, until reset.
- R6: Outputs as {`theme_o`,`task_o`,`tense_o`}: Start = 100, Play = 110, Vote = 001, Over = 000.
- R7: The outputs depend on the current state only. A change on `btn_i` between edges does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Branch button, sampled at each rising edge |
| theme_o | output | 1 | Request for the game theme music |
| task_o | output | 1 | Request for the player to do tasks |
| tense_o | output | 1 | Request for suspenseful music |

## Verification
The block has no tunable parameters: the two-bit encoding is fixed, so the bench builds the one and only configuration. With that configuration, all eight pairings of state and button value are within reach. The bench drives each pairing from a fresh reset and compares the result against its own transition and output table. Each state has a distinct output code, so the bench sees the state at the ports. It also changes the button and the reset between edges to show that the outputs only move at an edge.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_START = 2'b00,
        ST_PLAY  = 2'b01,
        ST_VOTE  = 2'b10,
        ST_OVER  = 2'b11
    } gstate_t;

    typedef struct packed {
        gstate_t st;
    } gctl_regs_t;

    typedef struct packed {
        logic theme;
        logic task_req;
        logic tense;
    } gctl_outs_t;
endpackage

// File: rtl/gctl_next.sv
// Minimized next-state equations over (s1, s0, g).
module gctl_next
    import gctl_pkg::*;
(
    input  gstate_t cur_i,
    input  logic    btn_i,
    output gstate_t nxt_o
);
    logic s1, s0, n1, n0;

    always_comb begin
        s1 = cur_i[1];
        s0 = cur_i[0];
        // n1 is the majority of s1, s0 and g.
        n1 = (s1 & s0) | (s0 & btn_i) | (s1 & btn_i);
        // n0 is 1 in Start, in Play while idle, in Vote on g, and in Over.
        n0 = (~s1 & ~s0) | (~s1 & ~btn_i) | (s1 & btn_i) | (s1 & s0);
        nxt_o = gstate_t'({n1, n0});
    end
endmodule

// File: rtl/gctl_outdec.sv
// Moore output equations: built from the state bits alone.
module gctl_outdec
    import gctl_pkg::*;
(
    input  gstate_t    cur_i,
    output gctl_outs_t out_o
);
    always_comb begin
        out_o.theme    = ~cur_i[1];
        out_o.task_req = ~cur_i[1] &  cur_i[0];
        out_o.tense    =  cur_i[1] & ~cur_i[0];
    end
endmodule

// File: rtl/gctl_game_fsm.sv
module gctl_game_fsm
    import gctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_i,
    output logic theme_o,
    output logic task_o,
    output logic tense_o
);
    gctl_regs_t r_d, r_q;
    gstate_t    nxt;
    gctl_outs_t outs;

    gctl_next u_next (
        .cur_i (r_q.st),
        .btn_i (btn_i),
        .nxt_o (nxt)
    );

    gctl_outdec u_outdec (
        .cur_i (r_q.st),
        .out_o (outs)
    );

    always_comb begin
        r_d = r_q;
        if (rst_i) begin
            r_d.st = ST_START;
        end else begin
            r_d.st = nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign theme_o = outs.theme;
    assign task_o  = outs.task_req;
    assign tense_o = outs.tense;

    // R1: a reset edge lands in Start
    a_r1_reset_start: assert property (@(posedge clk_i)
        rst_i |=> (r_q.st == ST_START));

    // R2: Start always advances to Play
    a_r2_start_to_play: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_START) |=> (r_q.st == ST_PLAY));

    // R3: Play branches on the button
    a_r3_play_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_PLAY && !btn_i) |=> (r_q.st == ST_PLAY));
    a_r3_play_call: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_PLAY && btn_i) |=> (r_q.st == ST_VOTE));

    // R4: Vote branches to Over or back to Start
    a_r4_vote_end: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_VOTE && btn_i) |=> (r_q.st == ST_OVER));
    a_r4_vote_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_VOTE && !btn_i) |=> (r_q.st == ST_START));

    // R5: Over holds
    a_r5_over_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_OVER) |=> (r_q.st == ST_OVER));

    // R6: at most one music request and tasks only in Play
    a_r6_music_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({theme_o, tense_o}) <= 1);
    a_r6_task_play: assert property (@(posedge clk_i) disable iff (rst_i)
        task_o |-> (r_q.st == ST_PLAY));

    // R7: outputs move only when the state moves
    a_r7_outs_follow_state: assert property (@(posedge clk_i) disable iff (rst_i)
        $stable(r_q.st) |-> $stable({theme_o, task_o, tense_o}));
endmodule

// File: tb/sim_gctl_game_fsm.sv
module sim_gctl_game_fsm;
    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic btn_i = 1'b0;
    logic theme_o, task_o, tense_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [1:0] model = 2'b00;

    gctl_game_fsm u0 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .btn_i   (btn_i),
        .theme_o (theme_o),
        .task_o  (task_o),
        .tense_o (tense_o)
    );

    always #10 clk_i = ~clk_i;

    // Reference table from the requirements (R2..R5).
    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic g);
        case (s)
            2'b00:   return 2'b01;
            2'b01:   return g ? 2'b10 : 2'b01;
            2'b10:   return g ? 2'b11 : 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    // R6 output table {theme, task, tense}.
    function automatic logic [2:0] ref_out(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b100;
            2'b01:   return 3'b110;
            2'b10:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {theme_o, task_o, tense_o};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    // Drive after an edge, wait for the next edge, settle.
    task automatic tick(input logic g);
        btn_i = g;
        @(posedge clk_i);
        model = rst_i ? 2'b00 : ref_next(model, g);
        #2;
    endtask

    task automatic do_reset;
        rst_i = 1'b1;
        tick(1'b1);
        rst_i = 1'b0;
    endtask

    task automatic go_to(input logic [1:0] s);
        do_reset();
        if (s >= 2'd1) tick(1'b0);
        if (s >= 2'd2) tick(1'b1);
        if (s == 2'd3) tick(1'b1);
    endtask

    task automatic t_reset_state;
        do_reset();
        check("R1 reset gives Start", 3'b100);
    endtask

    task automatic t_walk_all;
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 2; g++) begin
                go_to(2'(s));
                check("R6 state output", ref_out(2'(s)));
                tick(1'(g));
                if (s == 0)      check("R2 start step", ref_out(model));
                else if (s == 1) check("R3 play branch", ref_out(model));
                else if (s == 2) check("R4 vote branch", ref_out(model));
                else             check("R5 over hold", ref_out(model));
            end
        end
    endtask

    task automatic t_over_long_hold;
        go_to(2'd3);
        for (int i = 0; i < 10; i++) begin
            tick(1'(i % 2));
            check("R5 over long hold", 3'b000);
        end
    endtask

    task automatic t_play_idle_run;
        go_to(2'd1);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0);
            check("R3 play idle", 3'b110);
        end
        tick(1'b1);
        check("R3 play to vote", 3'b001);
    endtask

    task automatic t_button_between_edges;
        go_to(2'd1);
        btn_i = 1'b1;
        #3;
        check("R7 btn mid-cycle play", 3'b110);
        btn_i = 1'b0;
        #3;
        check("R7 btn release play", 3'b110);
        tick(1'b1);
        btn_i = 1'b0;
        #3;
        check("R7 btn mid-cycle vote", 3'b001);
    endtask

    task automatic t_sync_reset;
        for (int s = 1; s < 4; s++) begin
            go_to(2'(s));
            rst_i = 1'b1;
            #4;
            check("R1 no reset before edge", ref_out(2'(s)));
            tick(1'b0);
            rst_i = 1'b0;
            check("R1 reset from state", 3'b100);
        end
    endtask

    task automatic t_restart_loop;
        go_to(2'd2);
        tick(1'b0);
        check("R4 vote restart", 3'b100);
        tick(1'b1);
        check("R2 start with btn high", 3'b110);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk_i);
        #2;
        check("R1 initial reset", 3'b100);
        t_reset_state();
        t_walk_all();
        t_over_long_hold();
        t_play_idle_run();
        t_button_between_edges();
        t_sync_reset();
        t_restart_loop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule